// File: doc/BRIEF.md
# UART Modem Control and Status Unit

This unit holds the modem control byte and the modem status byte of a 16550-style serial port. It drives four control pins: data-terminal-ready, request-to-send and two general outputs. It samples four status pins (clear-to-send, data-set-ready, carrier-detect and ring) through a synchroniser chain. It records every change on those pins as a sticky event bit until software reads the status byte. A single `any_delta_o` flag gives the neighbouring interrupt logic a summary of pending events.

A two-state mode machine selects where the status lines come from. In `MODE_LINE`, the status lines follow the synchronised pins and the control pins follow the control byte. A control write with bit 4 set takes the `LINE_TO_LOOP` transition into `MODE_LOOP`. In that mode, the four control bits are fed back as the status lines, the external pins are disregarded, and the request-to-send and data-terminal-ready pins are held low. A control write with bit 4 clear takes the `LOOP_TO_LINE` transition back to `MODE_LINE`. Any other write leaves the state unchanged.

Reads use a one-cycle strobe. The read data is the value before the clear, and the clear takes effect at that clock edge.

Top module: `mdm_status_unit`

## Requirements
- R1: After reset the control byte reads 0x08 and the status byte reads 0xB0. `any_delta_o` is low, `out2_o` is high, and `rts_o`, `dtr_o` and `out1_o` are low.
- R2: A control write keeps write bits 4:0. Control bits 7:5 always read zero.
- R3: In `MODE_LINE`, control bit 0 drives `dtr_o`, bit 1 drives `rts_o`, bit 2 drives `out1_o` and bit 3 drives `out2_o`.
- R4: Status bits 7:4 show carrier-detect, ring, data-set-ready and clear-to-send, from bit 7 down to bit 4. A pin change shows there at the third rising edge after the change (two synchroniser stages plus the line register).
- R5: Status bit 3 (carrier), bit 1 (data-set-ready) and bit 0 (clear-to-send) are set by a change of their line in either direction. They stay set until read.
- R6: Status bit 2 is set only when the ring line falls from 1 to 0. A rise of the ring line leaves it clear.
- R7: A status read returns the pre-clear value. It clears bits 3:0 and leaves bits 7:4 unchanged.
- R8: A line event that lands on the same edge as a status read leaves its event bit set after the read.
- R9: In `MODE_LOOP` the status lines are taken from the control bits: OUT2 as carrier, OUT1 as ring, DTR as data-set-ready and RTS as clear-to-send. Changes made this way set event bits under R5 and R6.
- R10: In `MODE_LOOP`, `rts_o` and `dtr_o` are low, and changes on the external status pins have no effect on the status byte.
- R11: `any_delta_o` is high exactly when one or more of status bits 3:0 is set.
- R12: The mode machine enters `MODE_LOOP` on a write with bit 4 set and returns to `MODE_LINE` on a write with bit 4 clear. On return, the control bits drive the pins again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_i | input | 1 | Control byte write strobe |
| ctl_wdata_i | input | 8 | Control byte write data |
| stat_rd_i | input | 1 | Status byte read strobe (clears event bits) |
| cts_i | input | 1 | Clear-to-send pin, asynchronous |
| dsr_i | input | 1 | Data-set-ready pin, asynchronous |
| dcd_i | input | 1 | Carrier-detect pin, asynchronous |
| ri_i | input | 1 | Ring pin, asynchronous |
| ctl_rdata_o | output | 8 | Control byte read data |
| stat_rdata_o | output | 8 | Status byte read data |
| any_delta_o | output | 1 | High while any event bit is set |
| rts_o | output | 1 | Request-to-send pin |
| dtr_o | output | 1 | Data-terminal-ready pin |
| out1_o | output | 1 | General output 1 |
| out2_o | output | 1 | General output 2 |

## Verification
The bench drives ring rises and ring falls separately. A design that treats ring like the other lines would report an event on the rise. It places a clear-to-send drop exactly on the edge of a status read. A design that lets the clear win would lose that event, and a design that is off by one synchroniser stage would show the new line value one sample early. In loopback it toggles the external pins and expects no change, so a design that mixes in the pins is caught. It also checks the event pattern produced by changing the control bits, which exposes a wrong bit mapping.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    typedef enum logic {
        MODE_LINE = 1'b0,
        MODE_LOOP = 1'b1
    } mdm_mode_e;

    localparam int LINE_W = 4;
    localparam int CTL_W  = 4;
    localparam int STAT_W = 2 * LINE_W;

    // positions inside the four-bit line vector (also status bits - 4)
    localparam int LN_CTS = 0;
    localparam int LN_DSR = 1;
    localparam int LN_RI  = 2;
    localparam int LN_DCD = 3;

    // positions inside the control byte
    localparam int CB_DTR  = 0;
    localparam int CB_RTS  = 1;
    localparam int CB_OUT1 = 2;
    localparam int CB_OUT2 = 3;
    localparam int CB_LOOP = 4;

    localparam logic [LINE_W-1:0] LINES_RST = 4'b1011;
    localparam logic [CTL_W-1:0]  CTL_RST   = 4'b1000;

    // feed control bits back as status lines
    function automatic logic [LINE_W-1:0] loop_map(input logic [CTL_W-1:0] c);
        logic [LINE_W-1:0] r;
        r[LN_DCD] = c[CB_OUT2];
        r[LN_RI]  = c[CB_OUT1];
        r[LN_DSR] = c[CB_DTR];
        r[LN_CTS] = c[CB_RTS];
        return r;
    endfunction

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int                WIDTH   = 4,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/mdm_ctl_fsm.sv
module mdm_ctl_fsm
    import mdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        ctl_o,
    output logic [CTL_W-1:0]  ctl_bits_o,
    output logic              loop_o,
    output logic              rts_o,
    output logic              dtr_o,
    output logic              out1_o,
    output logic              out2_o
);

    mdm_mode_e         mode_q, mode_n;
    logic [CTL_W-1:0]  ctl_q;
    logic              unused_hi;

    assign unused_hi = ^wdata_i[7:CB_LOOP+1];

    // next-state logic: LINE_TO_LOOP / LOOP_TO_LINE
    always_comb begin
        mode_n = mode_q;
        unique case (mode_q)
            MODE_LINE: if (wr_i &&  wdata_i[CB_LOOP]) mode_n = MODE_LOOP;
            MODE_LOOP: if (wr_i && !wdata_i[CB_LOOP]) mode_n = MODE_LINE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_LINE;
        else        mode_q <= mode_n;
    end

    // control bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ctl_q <= CTL_RST;
        else if (wr_i) ctl_q <= wdata_i[CTL_W-1:0];
    end

    // output process
    always_comb begin
        out1_o = ctl_q[CB_OUT1];
        out2_o = ctl_q[CB_OUT2];
        unique case (mode_q)
            MODE_LINE: begin
                rts_o  = ctl_q[CB_RTS];
                dtr_o  = ctl_q[CB_DTR];
                loop_o = 1'b0;
            end
            MODE_LOOP: begin
                rts_o  = 1'b0;
                dtr_o  = 1'b0;
                loop_o = 1'b1;
            end
        endcase
    end

    assign ctl_bits_o = ctl_q;
    assign ctl_o      = {3'b000, (mode_q == MODE_LOOP), ctl_q};

    // R10
    r10_loop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o[CB_LOOP]) |-> (!rts_o && !dtr_o));

    // R2
    r2_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (ctl_o == {3'b000, $past(wdata_i[CB_LOOP:0])}));

endmodule

// File: rtl/mdm_stat_reg.sv
module mdm_stat_reg
    import mdm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_i,
    input  logic [LINE_W-1:0]  src_i,
    output logic [STAT_W-1:0]  stat_o,
    output logic               any_delta_o
);

    logic [LINE_W-1:0] line_q;
    logic [LINE_W-1:0] delta_q, delta_n;
    logic [LINE_W-1:0] flip;
    logic [LINE_W-1:0] new_evt;

    assign flip = line_q ^ src_i;

    always_comb begin
        new_evt         = flip;
        new_evt[LN_RI]  = line_q[LN_RI] & ~src_i[LN_RI];
        delta_n         = (rd_i ? '0 : delta_q) | new_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q  <= LINES_RST;
            delta_q <= '0;
        end else begin
            line_q  <= src_i;
            delta_q <= delta_n;
        end
    end

    assign stat_o      = {line_q, delta_q};
    assign any_delta_o = |delta_q;

    // R6
    r6_ri_trailing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta_q[LN_RI]) |-> ($past(line_q[LN_RI]) && !line_q[LN_RI]));

    // R7
    r7_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && (new_evt == '0)) |=> (delta_q == '0));

    // R8
    r8_keep_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (new_evt != '0) |=> ((delta_q & $past(new_evt)) == $past(new_evt)));

    // R4
    r4_line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(src_i) |=> $stable(line_q));

endmodule

// File: rtl/mdm_status_unit.sv
module mdm_status_unit
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr_i,
    input  logic [7:0] ctl_wdata_i,
    input  logic       stat_rd_i,
    input  logic       cts_i,
    input  logic       dsr_i,
    input  logic       dcd_i,
    input  logic       ri_i,
    output logic [7:0] ctl_rdata_o,
    output logic [7:0] stat_rdata_o,
    output logic       any_delta_o,
    output logic       rts_o,
    output logic       dtr_o,
    output logic       out1_o,
    output logic       out2_o
);

    logic [LINE_W-1:0] pins_raw, pins_sync, src;
    logic [CTL_W-1:0]  ctl_bits;
    logic              loop;

    always_comb begin
        pins_raw         = '0;
        pins_raw[LN_CTS] = cts_i;
        pins_raw[LN_DSR] = dsr_i;
        pins_raw[LN_RI]  = ri_i;
        pins_raw[LN_DCD] = dcd_i;
    end

    mdm_sync #(
        .WIDTH   (LINE_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (LINES_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_raw),
        .q_o   (pins_sync)
    );

    mdm_ctl_fsm u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (ctl_wr_i),
        .wdata_i    (ctl_wdata_i),
        .ctl_o      (ctl_rdata_o),
        .ctl_bits_o (ctl_bits),
        .loop_o     (loop),
        .rts_o      (rts_o),
        .dtr_o      (dtr_o),
        .out1_o     (out1_o),
        .out2_o     (out2_o)
    );

    assign src = loop ? loop_map(ctl_bits) : pins_sync;

    mdm_stat_reg u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_i        (stat_rd_i),
        .src_i       (src),
        .stat_o      (stat_rdata_o),
        .any_delta_o (any_delta_o)
    );

    // R11
    r11_any_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rdata_o[3:0] == 4'h0) |-> !any_delta_o);

endmodule

// File: tb/test_mdm_status_unit.sv
module test_mdm_status_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic       stat_rd = 1'b0;
    logic       cts = 1'b1, dsr = 1'b1, dcd = 1'b1, ri = 1'b0;
    logic [7:0] ctl_rdata, stat_rdata;
    logic       any_delta, rts, dtr, out1, out2;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    mdm_status_unit i_mdm_status_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr_i     (ctl_wr),
        .ctl_wdata_i  (ctl_wdata),
        .stat_rd_i    (stat_rd),
        .cts_i        (cts),
        .dsr_i        (dsr),
        .dcd_i        (dcd),
        .ri_i         (ri),
        .ctl_rdata_o  (ctl_rdata),
        .stat_rdata_o (stat_rdata),
        .any_delta_o  (any_delta),
        .rts_o        (rts),
        .dtr_o        (dtr),
        .out1_o       (out1),
        .out2_o       (out2)
    );

    // {lines dcd,ri,dsr,cts ; expected status read}
    localparam logic [11:0] VEC [8] = '{
        12'hBB0, 12'hFF0, 12'hBB4, 12'hAA1,
        12'h00A, 12'hFFB, 12'h55A, 12'h114
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_lines(input logic [3:0] v);
        @(negedge clk);
        {dcd, ri, dsr, cts} = v;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic ctl_write(input logic [7:0] v);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic stat_read(output logic [7:0] d);
        @(negedge clk);
        stat_rd = 1'b1;
        #1 d = stat_rdata;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic peek(output logic [7:0] d);
        @(negedge clk);
        #1 d = stat_rdata;
    endtask

    function automatic logic [7:0] pins();
        return {4'h0, out2, out1, rts, dtr};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        wait_cyc(3);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        #1;
        chk("R1 ctl", ctl_rdata, 8'h08);
        chk("R1 stat", stat_rdata, 8'hB0);
        chk("R1 any_delta", {7'd0, any_delta}, 8'h00);
        chk("R1 pins", pins(), 8'h08);

        // table: R4 R5 R6 R7
        for (int i = 0; i < 8; i++) begin
            set_lines(VEC[i][11:8]);
            wait_cyc(4);
            stat_read(d);
            chk($sformatf("R5/R6 vector %0d", i), d, VEC[i][7:0]);
        end

        // R2 R3 control byte
        ctl_write(8'hEF);
        #1;
        chk("R2 ctl masked", ctl_rdata, 8'h0F);
        chk("R3 pins all", pins(), 8'h0F);
        ctl_write(8'h05);
        #1;
        chk("R3 pins dtr/out1", pins(), 8'h05);
        ctl_write(8'h08);

        // R5 R11 sticky, then R7 clear
        set_lines(4'b0000);
        wait_cyc(4);
        set_lines(4'b0001);
        wait_cyc(4);
        peek(d);
        chk("R5 sticky", d, 8'h11);
        chk("R11 any_delta set", {7'd0, any_delta}, 8'h01);
        stat_read(d);
        chk("R7 read value", d, 8'h11);
        peek(d);
        chk("R7 cleared", d, 8'h10);
        chk("R11 any_delta clear", {7'd0, any_delta}, 8'h00);

        // R8 event on the read edge, R4 exact latency
        @(negedge clk) cts = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk) stat_rd = 1'b1;
        #1 chk("R4 not yet visible", stat_rdata, 8'h10);
        @(posedge clk);
        @(negedge clk) stat_rd = 1'b0;
        #1 chk("R8 event kept", stat_rdata, 8'h01);
        stat_read(d);

        // R9 R10 loopback
        ctl_write(8'h15);
        #1;
        chk("R12 ctl in loop", ctl_rdata, 8'h15);
        chk("R10 pins in loop", pins(), 8'h04);
        wait_cyc(3);
        peek(d);
        chk("R9 loop map", d, 8'h62);
        stat_read(d);
        set_lines(4'b1111);
        wait_cyc(6);
        peek(d);
        chk("R10 external ignored", d, 8'h60);
        ctl_write(8'h1A);
        wait_cyc(3);
        peek(d);
        chk("R9 loop deltas", d, 8'h9F);
        stat_read(d);

        // R12 return to line mode
        set_lines(4'b1001);
        wait_cyc(4);
        ctl_write(8'h03);
        #1;
        chk("R12 ctl", ctl_rdata, 8'h03);
        chk("R12 pins restored", pins(), 8'h03);
        wait_cyc(4);
        peek(d);
        chk("R12 lines from pins", d, 8'h90);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule